// File: doc/BRIEF.md
# TDC Hit Buffer with Window Readout

This block collects hit strobes from sixteen time-to-digital converter channels and keeps each hit's coarse time in a small queue per channel. The time is a 16-bit free-running counter in 0.5 ns steps, so it covers 32 µs and then wraps. Hits are stored as they arrive. The block does not wait for a trigger to store them.

A trigger pulse records the current counter value as the event time, along with a lookback offset and a window width. The block then visits the channels in round-robin order. It sends out the buffered hits whose time lies inside the window and discards hits older than the window. Hits newer than the window end stay queued for a later trigger. Each event ends with a marker word that carries the trigger time.

While the block is idle, any queued hit older than a fixed maximum age is dropped, so the queues never hold stale data.

Top module: `tdc_window_collector`

## Requirements
- R1: The time counter is 0 after reset and adds 1 (modulo 65536) on every clock. A hit on `hit_i[c]` stores the counter value of that clock cycle.
- R2: An event with trigger time T, offset O and width W sends a stored hit of time h exactly when A = (T - h) mod 65536 satisfies A <= O and O - A < W. The word is `out_data_o` = {bit 20 = 0, bits 19:16 = channel, bits 15:0 = h}.
- R3: Each channel queue holds 4 hits. A hit that arrives when its queue is full is dropped and sets `overflow_o[c]`, which stays set until reset.
- R4: During an event, queued hits older than the window (A > O) are discarded without output. A hit newer than the window end, and everything queued behind it on that channel, stays for later events.
- R5: Within an event, channels are visited round-robin, starting at channel 0. Each visit handles only the head entry of one channel, so the words of different channels interleave.
- R6: After all channels are done, one marker word {bit 20 = 1, bits 19:16 = 0, bits 15:0 = T} is sent, and the block then returns to idle.
- R7: `busy_o` rises in the clock cycle after an accepted trigger and falls after the marker is transferred. A trigger while busy is ignored.
- R8: While idle, the head hit of a queue is dropped once its age (counter minus hit time, modulo 65536) exceeds MAX_AGE (default 1000).
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` hold.
- R10: After reset, `out_valid_o`, `busy_o` and `overflow_o` are all 0, and `out_valid_o` is 0 whenever the block is idle.
- R11: An event covers only the hits queued before its trigger cycle, so a hit in the trigger cycle waits for the next event. Windows that span the counter wrap select correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick is one time bin |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | 16 | Hit strobe per channel |
| trig_i | input | 1 | Trigger pulse |
| win_offset_i | input | 16 | Lookback from trigger to window start, in bins |
| win_width_i | input | 16 | Window length, in bins |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 21 | {marker flag, channel, time} |
| busy_o | output | 1 | Event readout in progress |
| overflow_o | output | 16 | Sticky queue-overflow flag per channel |

## Verification
The assertions assume three things. First, `win_offset_i` never exceeds MAX_AGE. Second, any hit still queued at a trigger is younger than one full counter period. Third, the consumer only drops `out_ready_i` while a word is being offered. The stimulus meets these assumptions. It uses offsets of a few hundred bins at most. It waits longer than MAX_AGE between scenarios, so the idle purge empties every queue. It drives the trigger, hits and ready on falling edges. The wrap case places its hits just below 65536 and triggers just after the counter passes zero.

// File: rtl/tdc_hit_pkg.sv
package tdc_hit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_MARK} rd_state_e;
  typedef enum logic [1:0] {CLS_OLD, CLS_IN, CLS_NEW} hit_class_e;
endpackage

// File: rtl/tdc_hit_fifo.sv
module tdc_hit_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [W-1:0]                   data_i,
  input  logic                           pop_i,
  output logic [W-1:0]                   head_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;   // full is judged before a same-cycle pop
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tdc_rr_arbiter.sv
module tdc_rr_arbiter #(
  parameter int N = 16
) (
  input  logic [N-1:0]         req_i,
  input  logic [$clog2(N)-1:0] last_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IW = $clog2(N);

  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 1; i <= N; i++) begin
      int j;
      j = (int'(last_i) + i) % N;
      if (!found && req_i[j]) begin
        found = 1'b1;
        idx_o = IW'(j);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/tdc_readout_ctrl.sv
module tdc_readout_ctrl
  import tdc_hit_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 4,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int CW    = $clog2(DEPTH+1),
  localparam int OUT_W = 1 + CHW + TS_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             trig_i,
  input  logic [TS_W-1:0]                  ts_i,
  input  logic [TS_W-1:0]                  offset_i,
  input  logic [TS_W-1:0]                  width_i,
  input  logic [NUM_CH-1:0][CW-1:0]        count_i,
  input  logic [NUM_CH-1:0][TS_W-1:0]      head_i,
  input  logic                             out_ready_i,
  output logic [NUM_CH-1:0]                pop_o,
  output logic                             out_valid_o,
  output logic [OUT_W-1:0]                 out_data_o,
  output logic                             busy_o
);
  rd_state_e                   state_q;
  logic [TS_W-1:0]             trig_ts_q, off_q, wid_q;
  logic [NUM_CH-1:0][CW-1:0]   rem_q;
  logic [CHW-1:0]              last_q, gnt;
  logic [NUM_CH-1:0]           req;
  logic                        any_req, act, clr;
  logic [TS_W-1:0]             head_sel, age;
  hit_class_e                  cls;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) req[c] = (rem_q[c] != '0);
  end

  tdc_rr_arbiter #(.N(NUM_CH)) u_arb (
    .req_i (req),
    .last_i(last_q),
    .any_o (any_req),
    .idx_o (gnt)
  );

  assign head_sel = head_i[gnt];
  assign age      = trig_ts_q - head_sel;   // modulo 2^TS_W

  always_comb begin
    if (age > off_q)               cls = CLS_OLD;
    else if ((off_q - age) < wid_q) cls = CLS_IN;
    else                           cls = CLS_NEW;
  end

  always_comb begin
    pop_o       = '0;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    act         = 1'b0;
    clr         = 1'b0;
    case (state_q)
      ST_SCAN: if (any_req) begin
        case (cls)
          CLS_OLD: begin
            pop_o[gnt] = 1'b1;
            act        = 1'b1;
          end
          CLS_IN: begin
            out_valid_o = 1'b1;
            out_data_o  = {1'b0, gnt, head_sel};
            if (out_ready_i) begin
              pop_o[gnt] = 1'b1;
              act        = 1'b1;
            end
          end
          default: begin
            act = 1'b1;
            clr = 1'b1;  // rest of this queue is newer than the window
          end
        endcase
      end
      ST_MARK: begin
        out_valid_o = 1'b1;
        out_data_o  = {1'b1, CHW'(0), trig_ts_q};
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      trig_ts_q <= '0;
      off_q     <= '0;
      wid_q     <= '0;
      rem_q     <= '0;
      last_q    <= CHW'(NUM_CH-1);
    end else begin
      case (state_q)
        ST_IDLE: if (trig_i) begin
          state_q   <= ST_SCAN;
          trig_ts_q <= ts_i;
          off_q     <= offset_i;
          wid_q     <= width_i;
          rem_q     <= count_i;
          last_q    <= CHW'(NUM_CH-1);
        end
        ST_SCAN: begin
          if (!any_req) state_q <= ST_MARK;
          else if (act) begin
            last_q <= gnt;
            if (clr) rem_q[gnt] <= '0;
            else     rem_q[gnt] <= rem_q[gnt] - CW'(1);
          end
        end
        ST_MARK: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdc_window_collector.sv
module tdc_window_collector #(
  parameter int NUM_CH  = 16,
  parameter int TS_W    = 16,
  parameter int DEPTH   = 4,
  parameter int MAX_AGE = 1000,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int CW     = $clog2(DEPTH+1),
  localparam int OUT_W  = 1 + CHW + TS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              trig_i,
  input  logic [TS_W-1:0]   win_offset_i,
  input  logic [TS_W-1:0]   win_width_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              busy_o,
  output logic [NUM_CH-1:0] overflow_o
);
  logic [TS_W-1:0]            ts_q;
  logic [NUM_CH-1:0][TS_W-1:0] head;
  logic [NUM_CH-1:0][CW-1:0]  cnt;
  logic [NUM_CH-1:0]          full, stale, scan_pop, fifo_pop;
  logic [NUM_CH-1:0]          ovf_q;
  logic                       purge_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + TS_W'(1);
  end

  // purge only when no event is latched or being latched
  assign purge_en = !busy_o && !trig_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [TS_W-1:0] age_now;

    tdc_hit_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (hit_i[g]),
      .data_i (ts_q),
      .pop_i  (fifo_pop[g]),
      .head_o (head[g]),
      .count_o(cnt[g]),
      .full_o (full[g])
    );

    assign age_now     = ts_q - head[g];
    assign stale[g]    = (cnt[g] != '0) && (age_now > TS_W'(MAX_AGE));
    assign fifo_pop[g] = (purge_en && stale[g]) || scan_pop[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ovf_q[g] <= 1'b0;
      else if (hit_i[g] && full[g]) ovf_q[g] <= 1'b1;
    end
  end

  assign overflow_o = ovf_q;

  tdc_readout_ctrl #(.NUM_CH(NUM_CH), .TS_W(TS_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .ts_i       (ts_q),
    .offset_i   (win_offset_i),
    .width_i    (win_width_i),
    .count_i    (cnt),
    .head_i     (head),
    .out_ready_i(out_ready_i),
    .pop_o      (scan_pop),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/tdc_window_collector_chk.sv
module tdc_window_collector_chk #(
  parameter int NUM_CH = 16,
  parameter int OUT_W  = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [OUT_W-1:0]  out_data_o,
  input logic              busy_o,
  input logic [NUM_CH-1:0] overflow_o
);
  localparam int CHW = $clog2(NUM_CH);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_sticky_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|overflow_o) |=> ((overflow_o & $past(overflow_o)) == $past(overflow_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o);

  assert_trig_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy_o |=> busy_o);

  assert_busy_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(out_valid_o && out_ready_i && out_data_o[OUT_W-1]) |=> busy_o);

  assert_marker_chan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_data_o[OUT_W-1] |-> out_data_o[OUT_W-2 -: CHW] == '0);
endmodule

bind tdc_window_collector tdc_window_collector_chk #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .busy_o     (busy_o),
  .overflow_o (overflow_o)
);

// File: tb/sim_tdc_window_collector.sv
`timescale 1ns/1ps
module sim_tdc_window_collector;
  localparam int MAX_AGE = 1000;
  localparam int DEPTH   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hit_i = '0;
  logic        trig = 1'b0;
  logic [15:0] woff = '0, wwid = '0;
  logic        out_valid, ready = 1'b0, busy;
  logic [20:0] out_data;
  logic [15:0] ovf;

  always #2 clk = ~clk;

  tdc_window_collector u0 (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit_i), .trig_i(trig),
    .win_offset_i(woff), .win_width_i(wwid), .out_valid_o(out_valid),
    .out_ready_i(ready), .out_data_o(out_data), .busy_o(busy), .overflow_o(ovf)
  );

  logic [15:0] tb_ts;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_ts <= '0; else tb_ts <= tb_ts + 16'd1;

  int checks = 0, fails = 0;
  logic [15:0] mq [16][8];
  int          mcnt [16];
  logic [20:0] exp_w [64];
  int          n_exp;
  logic [15:0] t_evt;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic void mpop(input int c);
    for (int k = 0; k < 7; k++) mq[c][k] = mq[c][k+1];
    mcnt[c]--;
  endfunction

  function automatic void build_exp(input logic [15:0] t, input logic [15:0] off, input logic [15:0] wid);
    int rem [16];
    int last;
    last = 15;
    n_exp = 0;
    for (int c = 0; c < 16; c++) rem[c] = mcnt[c];
    while (1) begin
      int sel;
      logic [15:0] h, age;
      sel = -1;
      for (int i = 1; i <= 16; i++) begin
        int j;
        j = (last + i) % 16;
        if (sel < 0 && rem[j] > 0) sel = j;
      end
      if (sel < 0) break;
      h = mq[sel][0];
      age = t - h;
      if (age > off) begin
        mpop(sel); rem[sel]--;
      end else if ((off - age) < wid) begin
        exp_w[n_exp] = {1'b0, 4'(sel), h};
        n_exp++;
        mpop(sel); rem[sel]--;
      end else rem[sel] = 0;
      last = sel;
    end
    exp_w[n_exp] = {1'b1, 4'h0, t};
  endfunction

  task automatic flush();
    repeat (MAX_AGE + 12) @(negedge clk);
    for (int c = 0; c < 16; c++) mcnt[c] = 0;
  endtask

  task automatic push_model(input logic [15:0] m);
    for (int c = 0; c < 16; c++)
      if (m[c] && mcnt[c] < DEPTH) begin
        mq[c][mcnt[c]] = tb_ts;
        mcnt[c]++;
      end
  endtask

  task automatic hit(input logic [15:0] m);
    @(negedge clk);
    hit_i = m;
    push_model(m);
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic start_evt(input logic [15:0] off, input logic [15:0] wid, input logic [15:0] m);
    @(negedge clk);
    trig = 1'b1; woff = off; wwid = wid; hit_i = m;
    t_evt = tb_ts;
    build_exp(tb_ts, off, wid);
    push_model(m);
    @(negedge clk);
    trig = 1'b0; hit_i = '0;
  endtask

  task automatic drain(input string tag, input int mode);
    logic [20:0] got [64];
    int n = 0, guard = 0;
    bit done = 0;
    while (!done && guard < 500) begin
      ready = (mode == 0) ? 1'b1 : ((guard % 3) != 0);
      if (out_valid && ready) begin
        if (n < 64) got[n] = out_data;
        n++;
        if (out_data[20]) done = 1;
      end
      @(negedge clk);
      guard++;
    end
    ready = 1'b0;
    chk(tag, "word count", n, n_exp + 1);
    for (int i = 0; i <= n_exp && i < n; i++) chk(tag, $sformatf("word %0d", i), got[i], exp_w[i]);
  endtask

  task automatic t_reset();
    chk("R10", "valid after reset", out_valid, 0);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "overflow after reset", ovf, 0);
  endtask

  task automatic t_window();
    flush();
    hit(16'h0004);
    repeat (5) @(negedge clk);
    hit(16'h0084);
    repeat (5) @(negedge clk);
    hit(16'h0080);
    repeat (20) @(negedge clk);
    hit(16'h0004);
    repeat (3) @(negedge clk);
    start_evt(16'd30, 16'd14, '0);
    drain("R2/R1/R4", 0);
    chk("R4", "newer hit kept in queue", mcnt[2] > 0, 1);
    repeat (4) @(negedge clk);
    start_evt(16'd40, 16'd41, '0);
    drain("R4/R6", 0);
  endtask

  task automatic t_round_robin();
    flush();
    hit(16'h8021);
    hit(16'h0021);
    hit(16'h0001);
    start_evt(16'd100, 16'd200, '0);
    chk("R5", "expected six words", n_exp, 6);
    drain("R5", 0);
  endtask

  task automatic t_overflow();
    flush();
    repeat (6) hit(16'h0200);
    @(negedge clk);
    chk("R3", "overflow flag on ch9 only", ovf, 16'h0200);
    start_evt(16'd200, 16'd300, '0);
    drain("R3", 0);
    repeat (5) @(negedge clk);
    chk("R3", "overflow flag sticky", ovf, 16'h0200);
  endtask

  task automatic t_stall();
    flush();
    hit(16'h000e);
    hit(16'h0006);
    hit(16'h0008);
    start_evt(16'd50, 16'd51, '0);
    drain("R9", 1);
  endtask

  task automatic t_busy();
    flush();
    hit(16'h0040);
    hit(16'h0040);
    start_evt(16'd50, 16'd60, '0);
    chk("R7", "busy after trigger", busy, 1);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R7", "still busy", busy, 1);
    drain("R7", 0);
    repeat (3) @(negedge clk);
    chk("R7", "no second event valid", out_valid, 0);
    chk("R7", "idle after marker", busy, 0);
  endtask

  task automatic t_purge();
    flush();
    repeat (4) hit(16'h0010);
    repeat (MAX_AGE + 20) @(negedge clk);
    mcnt[4] = 0;
    repeat (4) hit(16'h0010);
    @(negedge clk);
    chk("R8", "no overflow after purge", ovf[4], 0);
    start_evt(16'd100, 16'd100, '0);
    chk("R8", "four fresh words expected", n_exp, 4);
    drain("R8", 0);
  endtask

  task automatic t_same_cycle();
    flush();
    hit(16'h0002);
    repeat (3) @(negedge clk);
    start_evt(16'd50, 16'd60, 16'h0002);
    chk("R11", "trigger-cycle hit excluded", n_exp, 1);
    drain("R11", 0);
    repeat (5) @(negedge clk);
    start_evt(16'd50, 16'd60, '0);
    chk("R11", "trigger-cycle hit in next event", n_exp, 1);
    drain("R11", 0);
  endtask

  task automatic t_wrap();
    while (tb_ts != 16'd65526) @(negedge clk);
    for (int c = 0; c < 16; c++) mcnt[c] = 0;
    hit(16'h0008);
    repeat (3) @(negedge clk);
    hit(16'h0008);
    while (tb_ts != 16'd3) @(negedge clk);
    start_evt(16'd14, 16'd12, '0);
    chk("R11", "wrap window hits", n_exp, 2);
    drain("R11/R1", 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_round_robin();
    t_overflow();
    t_stall();
    t_busy();
    t_purge();
    t_same_cycle();
    t_wrap();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=hung exp=finished");
    summary();
    $finish;
  end
endmodule